// File: doc/BRIEF.md
# Single-Step Debug State Controller

This block holds the software-step state of one processor core. A debugger arms stepping by setting a step-enable bit and then performing an exception return into the code to be stepped. The exception return decides, from the saved step bit and the debug-enable conditions at the two levels, whether stepping becomes active. After that, each instruction fetch advances a small state machine. The first fetch lets one instruction run. The next fetch is replaced by a step exception, and breakpoint checks on that fetch are suppressed.

Alongside the state machine the block forms what the exception needs. It gives the exception class from the source and target levels and a syndrome value that records whether an instruction completed and whether that instruction was an exclusive load. It decides whether the exception goes to the hypervisor level. It also gives the step bit to save on any exception entry.

Top module: `step_ctl`

## Requirements
- R1: The step state is 2 bits: 0 = inactive, 1 = active-pending, 2 = active-not-pending. Reset (synchronous, active high) gives inactive, a clear stepped flag, syndrome 0x22 and no step request. The value 3 never appears.
- R2: On `eret_valid` with `step_en` high, `eret_src_dbg_en` low, `eret_dst_dbg_en` high and `eret_tgt_is64` high, `eret_ss` equals `eret_saved_ss` in that cycle. On the next edge the state becomes active-pending if the saved bit is 0, or active-not-pending if it is 1. In any other exception return `eret_ss` is 0 and the state does not change.
- R3: A fetch in active-not-pending moves to inactive if `dbg_mask` is high or `step_en` is low. Otherwise it sets the sticky stepped flag and moves to active-pending.
- R4: A fetch in active-pending raises `step_take` and `bkpt_skip` in that cycle only when `dbg_mask` is low and `step_en` is high. In every case the state then becomes inactive and the exclusive-load tracker is cleared.
- R5: A fetch in the inactive state never raises `step_take`.
- R6: `syndrome` is 0x22, with bit 24 set while the stepped flag is set and bit 6 set when the previous value of the exclusive-load tracker is 1. Each set (by `excl_ld`) or clear (by an active-pending fetch) first copies the current tracker value into the previous value.
- R7: `exc_class` is 0x33 when `tgt_el` equals `src_el`, and 0x32 otherwise.
- R8: `route_hyp` is high exactly when `have_el2` and `nonsecure` are high, `src_el` is 0 or 1, and `trap_ge` or `trap_dbg` is high.
- R9: `entry_saved_ss` is 0 when `exc_entry_clr_ss` is high (step, supervisor, hypervisor or monitor call), and `cur_ss` otherwise. Every `exc_entry` clears the stepped flag on the next edge.
- R10: When an exception return and a fetch arrive in the same cycle, the exception return decides the next state and no step exception is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Step enable from debug control bit 0 |
| dbg_mask | input | 1 | Debug mask from processor state |
| eret_valid | input | 1 | Exception return this cycle |
| eret_saved_ss | input | 1 | Saved step bit being restored |
| eret_src_dbg_en | input | 1 | Debug enabled at the source level |
| eret_dst_dbg_en | input | 1 | Debug enabled at the destination level |
| eret_tgt_is64 | input | 1 | Debug target level runs in 64-bit state |
| fetch_valid | input | 1 | Instruction fetch strobe |
| excl_ld | input | 1 | Exclusive load executed |
| exc_entry | input | 1 | Exception entry this cycle |
| exc_entry_clr_ss | input | 1 | Entry kind forces saved step bit to 0 |
| cur_ss | input | 1 | Current step bit of processor state |
| src_el | input | 2 | Level the exception comes from |
| tgt_el | input | 2 | Level the exception is taken to |
| have_el2 | input | 1 | Hypervisor level implemented |
| nonsecure | input | 1 | Core in non-secure state |
| trap_ge | input | 1 | Trap-general-exceptions bit |
| trap_dbg | input | 1 | Trap-debug-exceptions bit |
| step_state | output | 2 | Current step state |
| eret_ss | output | 1 | Step bit to load on this exception return |
| step_take | output | 1 | Replace this fetch with a step exception |
| bkpt_skip | output | 1 | Suppress breakpoint check on this fetch |
| stepped | output | 1 | Sticky flag: an instruction completed |
| syndrome | output | 32 | Step exception syndrome |
| exc_class | output | 6 | Step exception class |
| route_hyp | output | 1 | Route the exception to the hypervisor level |
| entry_saved_ss | output | 1 | Step bit to save on exception entry |

## Verification
The assertions take the strobes as single-cycle events. They also take the state register to be written only through reset, exception return and fetch, so an unsigned value of 3 cannot be loaded from outside. The bench drives each strobe for one cycle, away from the clock edge, and holds every input low when no scenario needs it. It never raises `excl_ld` together with a fetch in active-pending, so each tracker update stays separate and its ordering is visible in the syndrome.

// File: rtl/step_ctl.sv
module step_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_en,
  input  logic       dbg_mask,
  input  logic       eret_valid,
  input  logic       eret_saved_ss,
  input  logic       eret_src_dbg_en,
  input  logic       eret_dst_dbg_en,
  input  logic       eret_tgt_is64,
  input  logic       fetch_valid,
  input  logic       excl_ld,
  input  logic       exc_entry,
  input  logic       exc_entry_clr_ss,
  input  logic       cur_ss,
  input  logic [1:0] src_el,
  input  logic [1:0] tgt_el,
  input  logic       have_el2,
  input  logic       nonsecure,
  input  logic       trap_ge,
  input  logic       trap_dbg,
  output logic [1:0] step_state,
  output logic       eret_ss,
  output logic       step_take,
  output logic       bkpt_skip,
  output logic       stepped,
  output logic [31:0] syndrome,
  output logic [5:0] exc_class,
  output logic       route_hyp,
  output logic       entry_saved_ss
);
  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_PEND = 2'd1;
  localparam logic [1:0] ST_RUN  = 2'd2;
  localparam logic [31:0] SYN_BASE = 32'h22;
  localparam int SYN_STEP_BIT = 24;
  localparam int SYN_LDX_BIT  = 6;

  logic [1:0] state_q, state_d;
  logic stepped_q, ldx_cur_q, ldx_prev_q;
  logic eret_arm, fetch_go, pend_fetch, run_fetch, may_step;

  assign eret_arm   = eret_valid & step_en & ~eret_src_dbg_en & eret_dst_dbg_en & eret_tgt_is64;
  assign eret_ss    = eret_arm & eret_saved_ss;
  assign fetch_go   = fetch_valid & ~eret_valid;
  assign pend_fetch = fetch_go & (state_q == ST_PEND);
  assign run_fetch  = fetch_go & (state_q == ST_RUN);
  assign may_step   = step_en & ~dbg_mask;

  always_comb begin
    state_d = state_q;
    if (eret_arm)
      state_d = eret_saved_ss ? ST_RUN : ST_PEND;
    else if (pend_fetch)
      state_d = ST_IDLE;
    else if (run_fetch)
      state_d = may_step ? ST_PEND : ST_IDLE;
    else if (state_q == 2'd3)
      state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      stepped_q  <= 1'b0;
      ldx_cur_q  <= 1'b0;
      ldx_prev_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (exc_entry)
        stepped_q <= 1'b0;
      else if (run_fetch && may_step)
        stepped_q <= 1'b1;
      if (pend_fetch || excl_ld) begin
        ldx_prev_q <= ldx_cur_q;
        ldx_cur_q  <= ~pend_fetch;
      end
    end
  end

  assign step_state     = state_q;
  assign step_take      = pend_fetch & may_step;
  assign bkpt_skip      = step_take;
  assign stepped        = stepped_q;
  assign syndrome       = SYN_BASE | (32'(stepped_q) << SYN_STEP_BIT) | (32'(ldx_prev_q) << SYN_LDX_BIT);
  assign exc_class      = (tgt_el == src_el) ? 6'h33 : 6'h32;
  assign route_hyp      = have_el2 & nonsecure & (src_el <= 2'd1) & (trap_ge | trap_dbg);
  assign entry_saved_ss = exc_entry_clr_ss ? 1'b0 : cur_ss;
endmodule

// File: rtl/step_ctl_chk.sv
module step_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_en,
  input logic       dbg_mask,
  input logic       eret_valid,
  input logic       eret_saved_ss,
  input logic       eret_src_dbg_en,
  input logic       eret_dst_dbg_en,
  input logic       eret_tgt_is64,
  input logic       fetch_valid,
  input logic       exc_entry,
  input logic [1:0] step_state,
  input logic       step_take,
  input logic       bkpt_skip,
  input logic       stepped,
  input logic [31:0] syndrome,
  input logic [5:0] exc_class
);
  logic arm;
  assign arm = eret_valid & step_en & ~eret_src_dbg_en & eret_dst_dbg_en & eret_tgt_is64;

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
    step_state != 2'd3);

  assert_eret_arms_R2: assert property (@(posedge clk) disable iff (rst)
    arm |=> step_state == ($past(eret_saved_ss) ? 2'd2 : 2'd1));

  assert_stepped_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !eret_valid && !exc_entry && step_state == 2'd2 && step_en && !dbg_mask)
      |=> stepped && step_state == 2'd1);

  assert_take_then_idle_R4: assert property (@(posedge clk) disable iff (rst)
    step_take |=> step_state == 2'd0);

  assert_take_skips_bkpt_R4: assert property (@(posedge clk) disable iff (rst)
    step_take |-> bkpt_skip && fetch_valid);

  assert_no_take_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (step_state == 2'd0) |-> !step_take);

  assert_syn_base_R6: assert property (@(posedge clk) disable iff (rst)
    (syndrome & ~32'h0100_0040) == 32'h22);

  assert_class_range_R7: assert property (@(posedge clk) disable iff (rst)
    exc_class == 6'h32 || exc_class == 6'h33);

  assert_entry_clears_R9: assert property (@(posedge clk) disable iff (rst)
    exc_entry |=> !stepped);

  assert_eret_priority_R10: assert property (@(posedge clk) disable iff (rst)
    eret_valid |-> !step_take);
endmodule

bind step_ctl step_ctl_chk u_chk (.*);

// File: tb/tb_step_ctl.sv
module tb_step_ctl;
  logic clk = 0, rst = 1;
  logic step_en = 0, dbg_mask = 0, eret_valid = 0, eret_saved_ss = 0;
  logic eret_src_dbg_en = 0, eret_dst_dbg_en = 0, eret_tgt_is64 = 0;
  logic fetch_valid = 0, excl_ld = 0, exc_entry = 0, exc_entry_clr_ss = 0, cur_ss = 0;
  logic [1:0] src_el = 0, tgt_el = 0;
  logic have_el2 = 0, nonsecure = 0, trap_ge = 0, trap_dbg = 0;
  logic [1:0] step_state;
  logic eret_ss, step_take, bkpt_skip, stepped, route_hyp, entry_saved_ss;
  logic [31:0] syndrome;
  logic [5:0] exc_class;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  step_ctl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_in();
    eret_valid = 0; fetch_valid = 0; excl_ld = 0; exc_entry = 0; exc_entry_clr_ss = 0;
  endtask

  task automatic do_eret(input logic ss, input logic src_en, input logic [1:0] exp_state, input logic exp_ss, input string req);
    eret_valid = 1; eret_saved_ss = ss; eret_src_dbg_en = src_en;
    eret_dst_dbg_en = 1; eret_tgt_is64 = 1;
    #0.5 chk(req, eret_ss, exp_ss);
    tick(); clear_in();
    chk(req, step_state, exp_state);
  endtask

  task automatic do_fetch(input logic exp_take, input logic [1:0] exp_state, input string req);
    fetch_valid = 1;
    #0.5 chk(req, step_take, exp_take);
    chk(req, bkpt_skip, exp_take);
    tick(); clear_in();
    chk(req, step_state, exp_state);
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick(); rst = 0;
    chk("R1", step_state, 0); chk("R1", stepped, 0);
    chk("R1", syndrome, 32'h22); chk("R1", step_take, 0);
  endtask

  task automatic t_eret();
    step_en = 1;
    do_eret(0, 0, 2'd1, 0, "R2");
    t_reset(); step_en = 1;
    do_eret(1, 0, 2'd2, 1, "R2");
    do_eret(0, 1, 2'd2, 0, "R2");
    step_en = 0;
    do_eret(1, 0, 2'd2, 0, "R2");
    step_en = 1;
  endtask

  task automatic t_run_masked();
    t_reset(); step_en = 1;
    do_eret(1, 0, 2'd2, 1, "R3");
    dbg_mask = 1; do_fetch(0, 2'd0, "R3"); dbg_mask = 0;
    chk("R3", stepped, 0);
    do_fetch(0, 2'd0, "R5");
  endtask

  task automatic t_full_step_ldx();
    t_reset(); step_en = 1;
    do_eret(1, 0, 2'd2, 1, "R3");
    do_fetch(0, 2'd1, "R3");
    chk("R3", stepped, 1);
    chk("R6", syndrome, 32'h0100_0022);
    excl_ld = 1; tick(); clear_in();
    chk("R6", syndrome, 32'h0100_0022);
    do_fetch(1, 2'd0, "R4");
    chk("R6", syndrome, 32'h0100_0062);
    exc_entry = 1; tick(); clear_in();
    chk("R9", stepped, 0);
    chk("R9", syndrome, 32'h62);
  endtask

  task automatic t_pend_masked();
    t_reset(); step_en = 1;
    do_eret(0, 0, 2'd1, 0, "R4");
    dbg_mask = 1; do_fetch(0, 2'd0, "R4"); dbg_mask = 0;
  endtask

  task automatic t_same_cycle();
    t_reset(); step_en = 1;
    do_eret(0, 0, 2'd1, 0, "R10");
    fetch_valid = 1; eret_valid = 1; eret_saved_ss = 1;
    #0.5 chk("R10", step_take, 0);
    tick(); clear_in();
    chk("R10", step_state, 2'd2);
  endtask

  task automatic t_class_route();
    src_el = 1; tgt_el = 1; #1 chk("R7", exc_class, 6'h33);
    tgt_el = 2; #1 chk("R7", exc_class, 6'h32);
    src_el = 0; #1 chk("R7", exc_class, 6'h32);
    have_el2 = 1; nonsecure = 1; trap_ge = 1; #1 chk("R8", route_hyp, 1);
    trap_ge = 0; #1 chk("R8", route_hyp, 0);
    trap_dbg = 1; #1 chk("R8", route_hyp, 1);
    src_el = 2; #1 chk("R8", route_hyp, 0);
    src_el = 1; nonsecure = 0; #1 chk("R8", route_hyp, 0);
    nonsecure = 1; have_el2 = 0; #1 chk("R8", route_hyp, 0);
  endtask

  task automatic t_entry_ss();
    cur_ss = 1; exc_entry_clr_ss = 1; #1 chk("R9", entry_saved_ss, 0);
    exc_entry_clr_ss = 0; #1 chk("R9", entry_saved_ss, 1);
    cur_ss = 0; #1 chk("R9", entry_saved_ss, 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_eret();
    t_run_masked();
    t_full_step_ldx();
    t_pend_masked();
    t_same_cycle();
    t_class_route();
    t_entry_ss();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule